// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Command Decoder

This block sits behind a serial receiver that has already assembled and checked a 16-bit command word. On each word strobe it decodes a three-bit command field, and sometimes a secondary opcode carried in the top data bits. It then moves 12-bit codes through two channels. Each channel has a staging (input) register that feeds a live (output) register. The live codes, one shutdown flag per channel, a general-purpose user output and an edge-mode bit that goes back to the serial receiver are the block's results.

The command word is laid out MSB first as follows. Bit 15 is the channel-address bit. Bits 14:13 are the two control bits. Bits 12:1 carry the 12-bit data, MSB at bit 12. Bit 0 is the trailing sub bit, which should be zero. The command field is bits 15:13. When that field is 000, bits 12:10 act as a secondary opcode and bit 9 carries the mode value.

An asynchronous active-low clear zeroes every staging and live register. A lockout input, when low, blocks all shutdown requests. A high-to-low transition on lockout wakes both channels at once, and each channel keeps the live code it held. A command is decoded combinationally and written on the clock edge at which the strobe is sampled high.

Top module: `dual_lane_cmd_decoder`

## Requirements
- R1: Command field 001 writes the data into staging register A, and 101 writes it into staging register B. Neither live code changes.
- R2: Command field 010 writes the data into staging A, and 110 writes it into staging B. In the same edge, both live registers take their channel's staging value, and the value just written is used for the addressed channel.
- R3: Command field 011 writes the data directly into both live registers and leaves both staging registers unchanged. Command field 100 copies each staging register into its own live register.
- R4: With command field 000, secondary opcode 001 copies staging A into live A, and secondary opcode 101 copies staging B into live B.
- R5: Command field 111 sets both shutdown flags. With command field 000, secondary opcode 110 sets the flag of channel A and 111 sets the flag of channel B. A shutdown leaves the staging and live codes unchanged.
- R6: Any command that loads a channel's staging register or writes its live register clears that channel's shutdown flag.
- R7: While lockout is low, shutdown commands leave the flags at 0. A falling edge on lockout clears both flags without waiting for a clock edge, and the live codes are kept.
- R8: With command field 000, secondary opcode 010 drives the user output low and 011 drives it high.
- R9: With command field 000, secondary opcode 100 copies bit 9 (D8) of the word into the edge-mode output: 1 selects mode 1 and 0 selects mode 0.
- R10: Clear low zeroes all four code registers without waiting for a clock edge. Shutdown flags, the user output and edge mode are not touched.
- R11: After reset, all codes, both flags, the user output, the edge mode and the sub-bit flag are 0.
- R12: Registers change only on a clock edge with the strobe high. Registers that the command does not name keep their values. Secondary opcode 000 changes nothing.
- R13: A word whose sub bit (bit 0) is 1 is still executed. It also sets a sticky flag that only reset clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| clr_n | input | 1 | Asynchronous active-low clear of all code registers |
| lock_n | input | 1 | Lockout; low blocks shutdown, falling edge wakes both channels |
| cmd_stb | input | 1 | One-cycle strobe marking a valid command word |
| cmd_word | input | 16 | Command word |
| code_a | output | 12 | Live code of channel A |
| code_b | output | 12 | Live code of channel B |
| sd_a | output | 1 | Channel A shutdown flag |
| sd_b | output | 1 | Channel B shutdown flag |
| user_out | output | 1 | User-programmable output |
| edge_mode | output | 1 | Output edge mode returned to the serial receiver |
| sub_flag | output | 1 | Sticky flag: a word arrived with a nonzero sub bit |

## Verification
The clocked properties run on every cycle. They check that clear holds both codes at zero and that low lockout holds both flags low. They also check that a cycle without a strobe changes no code, user output or edge mode, that a global shutdown with lockout high raises both flags, and that a direct write lands in both live codes. The sub-bit flag is checked to stay set. Some behaviour depends on what was staged several commands earlier, and only the bench's behavioural model can show it. This covers double buffering through staging, the addressed channel taking the new value in the load-and-update commands, and waking that preserves the pre-shutdown code. It also covers secondary opcodes that touch one channel and leave the other alone.

// File: rtl/dlcd_pkg.sv
package dlcd_pkg;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_LOAD_IN,
        OP_LOAD_UPD_ALL,
        OP_DIRECT_ALL,
        OP_UPD_ALL,
        OP_SHUT_ALL,
        OP_UPD_ONE,
        OP_SHUT_ONE,
        OP_USER_LO,
        OP_USER_HI,
        OP_EDGE_SET
    } op_e;

    typedef struct packed {
        logic [1:0] ld_in;
        logic [1:0] upd_in;
        logic       upd_dir;
        logic [1:0] shut;
        logic       set_user;
        logic       user_val;
        logic       set_mode;
        logic       mode_val;
    } ctl_t;

endpackage

// File: rtl/dlcd_decode.sv
module dlcd_decode
    import dlcd_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic [DATA_W+3:0] word,
    output op_e               op,
    output logic              chan,
    output ctl_t              ctl,
    output logic [DATA_W-1:0] data,
    output logic              sub_bad
);
    localparam int WORD_W = DATA_W + 4;

    logic [2:0] top3;
    logic [2:0] sub3;
    logic       d_mode;

    assign top3    = word[WORD_W-1 -: 3];
    assign sub3    = word[DATA_W -: 3];
    assign d_mode  = word[DATA_W-3];
    assign data    = word[DATA_W:1];
    assign sub_bad = word[0];

    // Command field, then secondary opcode when the field is zero
    always_comb begin
        op   = OP_NOP;
        chan = 1'b0;
        unique case (top3)
            3'b001: begin op = OP_LOAD_IN;      chan = 1'b0; end
            3'b101: begin op = OP_LOAD_IN;      chan = 1'b1; end
            3'b010: begin op = OP_LOAD_UPD_ALL; chan = 1'b0; end
            3'b110: begin op = OP_LOAD_UPD_ALL; chan = 1'b1; end
            3'b011: op = OP_DIRECT_ALL;
            3'b100: op = OP_UPD_ALL;
            3'b111: op = OP_SHUT_ALL;
            3'b000: begin
                unique case (sub3)
                    3'b000: op = OP_NOP;
                    3'b001: begin op = OP_UPD_ONE;  chan = 1'b0; end
                    3'b101: begin op = OP_UPD_ONE;  chan = 1'b1; end
                    3'b110: begin op = OP_SHUT_ONE; chan = 1'b0; end
                    3'b111: begin op = OP_SHUT_ONE; chan = 1'b1; end
                    3'b010: op = OP_USER_LO;
                    3'b011: op = OP_USER_HI;
                    3'b100: op = OP_EDGE_SET;
                endcase
            end
        endcase
    end

    // Operation to per-lane and config strobes
    always_comb begin
        ctl = '0;
        unique case (op)
            OP_NOP: ;
            OP_LOAD_IN:      ctl.ld_in[chan] = 1'b1;
            OP_LOAD_UPD_ALL: begin
                ctl.ld_in[chan] = 1'b1;
                ctl.upd_in      = 2'b11;
            end
            OP_DIRECT_ALL:   ctl.upd_dir = 1'b1;
            OP_UPD_ALL:      ctl.upd_in = 2'b11;
            OP_SHUT_ALL:     ctl.shut = 2'b11;
            OP_UPD_ONE:      ctl.upd_in[chan] = 1'b1;
            OP_SHUT_ONE:     ctl.shut[chan] = 1'b1;
            OP_USER_LO:      begin ctl.set_user = 1'b1; ctl.user_val = 1'b0; end
            OP_USER_HI:      begin ctl.set_user = 1'b1; ctl.user_val = 1'b1; end
            OP_EDGE_SET:     begin ctl.set_mode = 1'b1; ctl.mode_val = d_mode; end
            default: ;
        endcase
    end

endmodule

// File: rtl/dlcd_lane.sv
module dlcd_lane #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              lock_n,
    input  logic              stb,
    input  logic              ld_in,
    input  logic              upd_in,
    input  logic              upd_dir,
    input  logic              shut,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] code,
    output logic              sd
);
    logic [DATA_W-1:0] stage_q;
    logic [DATA_W-1:0] live_q;

    always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
        if (!rst_n || !clr_n) begin
            stage_q <= '0;
            live_q  <= '0;
        end else if (stb) begin
            if (ld_in) stage_q <= data;
            if (upd_dir)     live_q <= data;
            else if (upd_in) live_q <= ld_in ? data : stage_q;
        end
    end

    // Low lockout holds the flag clear; its falling edge wakes the lane
    always_ff @(posedge clk or negedge rst_n or negedge lock_n) begin
        if (!rst_n || !lock_n) begin
            sd <= 1'b0;
        end else if (stb) begin
            if (ld_in || upd_in || upd_dir) sd <= 1'b0;
            else if (shut)                  sd <= 1'b1;
        end
    end

    assign code = live_q;

endmodule

// File: rtl/dlcd_cfg.sv
module dlcd_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic set_user,
    input  logic user_val,
    input  logic set_mode,
    input  logic mode_val,
    input  logic sub_bad,
    output logic user_out,
    output logic edge_mode,
    output logic sub_flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            user_out  <= 1'b0;
            edge_mode <= 1'b0;
            sub_flag  <= 1'b0;
        end else if (stb) begin
            if (set_user) user_out  <= user_val;
            if (set_mode) edge_mode <= mode_val;
            if (sub_bad)  sub_flag  <= 1'b1;
        end
    end

endmodule

// File: rtl/dual_lane_cmd_decoder.sv
module dual_lane_cmd_decoder
    import dlcd_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              lock_n,
    input  logic              cmd_stb,
    input  logic [DATA_W+3:0] cmd_word,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic              sd_a,
    output logic              sd_b,
    output logic              user_out,
    output logic              edge_mode,
    output logic              sub_flag
);
    localparam int NUM_CH = 2;

    op_e               dec_op;
    logic              dec_chan;
    ctl_t              ctl;
    logic [DATA_W-1:0] dec_data;
    logic              dec_sub_bad;
    logic [DATA_W-1:0] lane_code [NUM_CH];
    logic [NUM_CH-1:0] lane_sd;

    dlcd_decode #(.DATA_W(DATA_W)) u_dec (
        .word    (cmd_word),
        .op      (dec_op),
        .chan    (dec_chan),
        .ctl     (ctl),
        .data    (dec_data),
        .sub_bad (dec_sub_bad)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
        dlcd_lane #(.DATA_W(DATA_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr_n   (clr_n),
            .lock_n  (lock_n),
            .stb     (cmd_stb),
            .ld_in   (ctl.ld_in[g]),
            .upd_in  (ctl.upd_in[g]),
            .upd_dir (ctl.upd_dir),
            .shut    (ctl.shut[g]),
            .data    (dec_data),
            .code    (lane_code[g]),
            .sd      (lane_sd[g])
        );
    end

    dlcd_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (cmd_stb),
        .set_user  (ctl.set_user),
        .user_val  (ctl.user_val),
        .set_mode  (ctl.set_mode),
        .mode_val  (ctl.mode_val),
        .sub_bad   (dec_sub_bad),
        .user_out  (user_out),
        .edge_mode (edge_mode),
        .sub_flag  (sub_flag)
    );

    assign code_a = lane_code[0];
    assign code_b = lane_code[1];
    assign sd_a   = lane_sd[0];
    assign sd_b   = lane_sd[1];

endmodule

// File: rtl/dlcd_checker.sv
module dlcd_checker #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              lock_n,
    input logic              cmd_stb,
    input logic [DATA_W+3:0] cmd_word,
    input logic [DATA_W-1:0] code_a,
    input logic [DATA_W-1:0] code_b,
    input logic              sd_a,
    input logic              sd_b,
    input logic              user_out,
    input logic              edge_mode,
    input logic              sub_flag
);
    a_r10_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (code_a == '0 && code_b == '0));

    a_r7_lockout_holds_awake: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_n |-> (!sd_a && !sd_b));

    a_r12_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (!cmd_stb && clr_n) |=> ($stable(code_a) && $stable(code_b)
                                 && $stable(user_out) && $stable(edge_mode)));

    a_r5_shut_all: assert property (@(posedge clk) disable iff (!rst_n || !lock_n)
        (cmd_stb && cmd_word[DATA_W+3 -: 3] == 3'b111) |=> (sd_a && sd_b));

    a_r3_direct_both: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (cmd_stb && cmd_word[DATA_W+3 -: 3] == 3'b011) |=>
            (code_a == $past(cmd_word[DATA_W:1]) && code_b == $past(cmd_word[DATA_W:1])
             && !sd_a && !sd_b));

    a_r13_sub_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        sub_flag |=> sub_flag);

    a_r8_user_high: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb && cmd_word[DATA_W+3 -: 3] == 3'b000 && cmd_word[DATA_W -: 3] == 3'b011)
            |=> user_out);

endmodule

bind dual_lane_cmd_decoder dlcd_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .lock_n    (lock_n),
    .cmd_stb   (cmd_stb),
    .cmd_word  (cmd_word),
    .code_a    (code_a),
    .code_b    (code_b),
    .sd_a      (sd_a),
    .sd_b      (sd_b),
    .user_out  (user_out),
    .edge_mode (edge_mode),
    .sub_flag  (sub_flag)
);

// File: tb/dual_lane_cmd_decoder_test.sv
module dual_lane_cmd_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        clr_n = 1'b1;
    logic        lock_n = 1'b1;
    logic        cmd_stb = 1'b0;
    logic [15:0] cmd_word = 16'h0;
    logic [11:0] code_a, code_b;
    logic        sd_a, sd_b, user_out, edge_mode, sub_flag;

    int    checks = 0;
    int    fails = 0;
    bit    done = 0;
    string tag = "R11";

    // behavioural reference state
    logic [11:0] m_in  [2];
    logic [11:0] m_out [2];
    logic        m_sd  [2];
    logic        m_user, m_mode, m_flag;

    dual_lane_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .lock_n(lock_n),
        .cmd_stb(cmd_stb), .cmd_word(cmd_word),
        .code_a(code_a), .code_b(code_b), .sd_a(sd_a), .sd_b(sd_b),
        .user_out(user_out), .edge_mode(edge_mode), .sub_flag(sub_flag)
    );

    always #10 clk = ~clk;

    task automatic model_zero();
        for (int i = 0; i < 2; i++) begin
            m_in[i] = '0; m_out[i] = '0; m_sd[i] = 1'b0;
        end
        m_user = 1'b0; m_mode = 1'b0; m_flag = 1'b0;
    endtask

    task automatic model_apply(input logic [15:0] w);
        logic [2:0]  t;
        logic [2:0]  s;
        logic [11:0] d;
        t = w[15:13]; s = w[12:10]; d = w[12:1];
        if (w[0]) m_flag = 1'b1;
        if (t == 3'b001 || t == 3'b101) begin
            m_in[t[2]] = d; m_sd[t[2]] = 1'b0;
        end else if (t == 3'b010 || t == 3'b110) begin
            m_in[t[2]] = d;
            for (int i = 0; i < 2; i++) begin m_out[i] = m_in[i]; m_sd[i] = 1'b0; end
        end else if (t == 3'b011) begin
            for (int i = 0; i < 2; i++) begin m_out[i] = d; m_sd[i] = 1'b0; end
        end else if (t == 3'b100) begin
            for (int i = 0; i < 2; i++) begin m_out[i] = m_in[i]; m_sd[i] = 1'b0; end
        end else if (t == 3'b111) begin
            if (lock_n) begin m_sd[0] = 1'b1; m_sd[1] = 1'b1; end
        end else begin
            case (s)
                3'b001, 3'b101: begin m_out[s[2]] = m_in[s[2]]; m_sd[s[2]] = 1'b0; end
                3'b110, 3'b111: if (lock_n) m_sd[s[0]] = 1'b1;
                3'b010: m_user = 1'b0;
                3'b011: m_user = 1'b1;
                3'b100: m_mode = w[9];
                default: ;
            endcase
        end
    endtask

    always @(posedge clk) begin
        if (rst_n && clr_n && cmd_stb) model_apply(cmd_word);
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (code_a !== m_out[0] || code_b !== m_out[1] || sd_a !== m_sd[0] ||
                sd_b !== m_sd[1] || user_out !== m_user || edge_mode !== m_mode ||
                sub_flag !== m_flag) begin
                fails++;
                $display("FAIL %s t=%0t actual a=%h b=%h sd=%b%b u=%b m=%b f=%b expected a=%h b=%h sd=%b%b u=%b m=%b f=%b",
                         tag, $time, code_a, code_b, sd_a, sd_b, user_out, edge_mode, sub_flag,
                         m_out[0], m_out[1], m_sd[0], m_sd[1], m_user, m_mode, m_flag);
            end
        end
    end

    function automatic logic [15:0] mk(input logic [2:0] t, input logic [11:0] d, input logic s0);
        return {t, d, s0};
    endfunction

    function automatic logic [15:0] sub(input logic [2:0] op, input logic d8);
        return {3'b000, op, d8, 8'h5A, 1'b0};
    endfunction

    task automatic cmd(input logic [15:0] w);
        @(negedge clk);
        cmd_stb = 1'b1; cmd_word = w;
        @(negedge clk);
        cmd_stb = 1'b0; cmd_word = ~w;   // R12: junk with strobe low
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        model_zero();
        tag = "R11";
        idle(3);
        rst_n = 1'b1;
        idle(2);

        tag = "R1";
        cmd(mk(3'b001, 12'h123, 1'b0));
        cmd(mk(3'b101, 12'h456, 1'b0));
        idle(1);

        tag = "R2";
        cmd(mk(3'b010, 12'hABC, 1'b0));
        cmd(mk(3'b110, 12'h789, 1'b0));

        tag = "R3";
        cmd(mk(3'b001, 12'h111, 1'b0));
        cmd(mk(3'b101, 12'h222, 1'b0));
        cmd(mk(3'b100, 12'h000, 1'b0));
        cmd(mk(3'b011, 12'hFFF, 1'b0));

        tag = "R4";
        cmd(mk(3'b001, 12'h333, 1'b0));
        cmd(sub(3'b001, 1'b0));
        cmd(mk(3'b101, 12'h444, 1'b0));
        cmd(sub(3'b101, 1'b0));

        tag = "R5";
        cmd(mk(3'b111, 12'h000, 1'b0));
        idle(1);
        cmd(mk(3'b100, 12'h000, 1'b0));
        cmd(sub(3'b110, 1'b0));
        cmd(sub(3'b111, 1'b0));

        tag = "R6";
        cmd(mk(3'b001, 12'h555, 1'b0));
        cmd(sub(3'b101, 1'b0));

        tag = "R7";
        @(negedge clk); #3 lock_n = 1'b0;
        cmd(mk(3'b111, 12'h000, 1'b0));
        cmd(sub(3'b110, 1'b0));
        @(negedge clk); #3 lock_n = 1'b1;
        cmd(mk(3'b111, 12'h000, 1'b0));
        @(negedge clk); #3 lock_n = 1'b0; m_sd[0] = 1'b0; m_sd[1] = 1'b0;
        idle(2);
        @(negedge clk); #3 lock_n = 1'b1;

        tag = "R8";
        cmd(sub(3'b011, 1'b0));
        cmd(sub(3'b010, 1'b1));
        cmd(sub(3'b011, 1'b0));

        tag = "R9";
        cmd(sub(3'b100, 1'b1));
        cmd(sub(3'b100, 1'b0));
        cmd(sub(3'b100, 1'b1));

        tag = "R12";
        cmd(sub(3'b000, 1'b1));
        idle(3);

        tag = "R13";
        cmd(mk(3'b011, 12'h9A5, 1'b1));
        cmd(mk(3'b001, 12'h0F0, 1'b0));

        tag = "R10";
        cmd(mk(3'b101, 12'h777, 1'b0));
        cmd(mk(3'b111, 12'h000, 1'b0));
        @(negedge clk); #3 clr_n = 1'b0;
        for (int i = 0; i < 2; i++) begin m_in[i] = '0; m_out[i] = '0; end
        idle(2);
        @(negedge clk); #3 clr_n = 1'b1;
        cmd(mk(3'b100, 12'h000, 1'b0));
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule